// File: doc/BRIEF.md
# Byte-Serial 40-Bit Accumulator Port

This block holds the 40-bit running sum of a math coprocessor. Each time the arithmetic unit finishes a multiply or a divide, it presents the result with a one-cycle valid pulse and an operation tag. The block adds that result to its stored value, and the sum wraps modulo 2^40. Shift and normalize results carry the same valid pulse, but they never change the sum.

A host on an 8-bit bus sees the 40-bit value through a single byte-wide register. Reads and writes each use their own byte pointer. Reads start at the top byte and move toward the bottom. Writes start at the bottom byte and move toward the top. Neither pointer wraps; each one stays at its last byte. Both pointers return to their start positions on reset, when any calculation result arrives, on a clear command and on a start command. The sum is cleared by reset, by the clear command, or by five accepted zero-byte writes in a row.

Top module: `byte_accum_port`

## Requirements
- R1: After reset the sum is zero, the read pointer is at byte 4 (bits 39:32), the write pointer is at byte 0 (bits 7:0), and `rd_data` is 0x00.
- R2: A `res_valid` pulse whose `res_op` is 2'b00 (multiply) or 2'b01 (divide) adds `res_value` to the sum modulo 2^40, with no overflow indication.
- R3: A `res_valid` pulse whose `res_op` is 2'b10 (shift) or 2'b11 (normalize) leaves the sum unchanged.
- R4: A read strobe returns the byte at the read pointer on `rd_data` one cycle later. Successive reads go from byte 4 down to byte 0, where byte i is bits 8i+7:8i.
- R5: Once the read pointer reaches byte 0 it stays there, so every further read returns byte 0.
- R6: An accepted write stores `wr_data` into byte i (bits 8i+7:8i) at the write pointer. Successive writes go from byte 0 up to byte 4.
- R7: Once the write pointer reaches byte 4 it stays there, so every further write overwrites byte 4.
- R8: Both pointers return to their start positions (read at byte 4, write at byte 0) on any `res_valid`, on `clr_cmd` and on `start_cmd`.
- R9: `clr_cmd` sets the whole sum to zero.
- R10: Five accepted writes of 0x00 in a row set the whole sum to zero, including bytes those writes did not reach. The run count restarts on a nonzero write and on every pointer restart.
- R11: Reading does not change the stored sum.
- R12: A partial load changes only the bytes written. Bytes that are not written keep their earlier values.
- R13: A host write in the same cycle as `res_valid`, `clr_cmd` or `start_cmd` is dropped. It changes neither the sum nor the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Host read of the port byte |
| rd_data | output | 8 | Registered byte returned by the last read |
| wr_strobe | input | 1 | Host write of the port byte |
| wr_data | input | 8 | Byte to write |
| res_valid | input | 1 | Arithmetic result complete, one-cycle pulse |
| res_value | input | 40 | Result value to accumulate |
| res_op | input | 2 | Operation tag: 00 multiply, 01 divide, 10 shift, 11 normalize |
| clr_cmd | input | 1 | Clear the sum and restart both pointers |
| start_cmd | input | 1 | Restart both pointers |

## Verification
The assertions assume that `res_valid`, `clr_cmd` and `start_cmd` are pulses whose effects last one cycle, and that `res_op` is stable whenever `res_valid` is high. The sum-stability properties assume that no write is accepted in the cycles they check. The stimulus drives every command as a single-cycle pulse between falling edges. It issues only one collision on purpose, a write together with a multiply result, to exercise R13. Every other write and read is separated from the pointer-restart commands.

// File: rtl/acc_port_pkg.sv
package acc_port_pkg;
  typedef enum logic [1:0] {
    OP_MUL   = 2'b00,
    OP_DIV   = 2'b01,
    OP_SHIFT = 2'b10,
    OP_NORM  = 2'b11
  } op_kind_e;

  function automatic logic op_accumulates(op_kind_e kind);
    return (kind == OP_MUL) || (kind == OP_DIV);
  endfunction
endpackage

// File: rtl/byte_ptr.sv
// Saturating byte pointer. ASCEND=1 counts up from 0, ASCEND=0 counts down
// from NUM-1. The pointer stops at its far end.
module byte_ptr #(
  parameter int NUM    = 5,
  parameter bit ASCEND = 1'b1,
  localparam int IW    = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] FIRST = ASCEND ? '0 : IW'(NUM - 1);
  localparam logic [IW-1:0] LAST  = ASCEND ? IW'(NUM - 1) : '0;

  logic [IW-1:0] next_idx;

  generate
    if (ASCEND) begin : g_up
      assign next_idx = idx + 1'b1;
    end else begin : g_down
      assign next_idx = idx - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx <= FIRST;
    end else if (step && (idx != LAST)) begin
      idx <= next_idx;
    end
  end
endmodule

// File: rtl/zero_run_det.sv
// Counts accepted zero-byte writes in a row and fires on the RUN-th one.
module zero_run_det #(
  parameter int BYTE_W = 8,
  parameter int RUN    = 5,
  localparam int CW    = $clog2(RUN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              wr_ok,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              fire
);
  logic [CW-1:0] run_cnt;
  logic          is_zero;

  assign is_zero = (wr_byte == '0);
  assign fire    = wr_ok && is_zero && (run_cnt == CW'(RUN - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      run_cnt <= '0;
    end else if (wr_ok) begin
      if (!is_zero || fire) begin
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_core.sv
// Accumulator storage: clear, add, byte load and registered byte read.
module acc_core #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 5,
  localparam int ACC_W    = BYTE_W * NUM_BYTES,
  localparam int IW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_all,
  input  logic              add_en,
  input  logic [ACC_W-1:0]  add_val,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_idx,
  output logic [ACC_W-1:0]  acc_q,
  output logic [BYTE_W-1:0] rd_data
);
  logic [ACC_W-1:0] byte_loaded;

  always_comb begin
    byte_loaded = acc_q;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (wr_idx == IW'(i)) begin
        byte_loaded[i*BYTE_W +: BYTE_W] = wr_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || zero_all) begin
      acc_q <= '0;
    end else if (add_en) begin
      acc_q <= acc_q + add_val;
    end else if (wr_en) begin
      acc_q <= byte_loaded;
    end
  end

  logic [BYTE_W-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_sel = acc_q[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_sel;
    end
  end
endmodule

// File: rtl/byte_accum_port.sv
module byte_accum_port #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 5,
  localparam int ACC_W    = BYTE_W * NUM_BYTES,
  localparam int IW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_strobe,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              res_valid,
  input  logic [ACC_W-1:0]  res_value,
  input  logic [1:0]        res_op,
  input  logic              clr_cmd,
  input  logic              start_cmd
);
  import acc_port_pkg::*;

  logic             restart;
  logic             wr_ok;
  logic             add_en;
  logic             zero_fire;
  logic             zero_all;
  logic [IW-1:0]    rd_idx;
  logic [IW-1:0]    wr_idx;
  logic [ACC_W-1:0] acc_q;

  assign restart  = res_valid || clr_cmd || start_cmd;
  assign wr_ok    = wr_strobe && !restart;
  assign add_en   = res_valid && op_accumulates(op_kind_e'(res_op));
  assign zero_all = clr_cmd || zero_fire;

  byte_ptr #(.NUM(NUM_BYTES), .ASCEND(1'b0)) u_rd_ptr (
    .clk(clk), .rst(rst), .restart(restart), .step(rd_strobe), .idx(rd_idx)
  );

  byte_ptr #(.NUM(NUM_BYTES), .ASCEND(1'b1)) u_wr_ptr (
    .clk(clk), .rst(rst), .restart(restart), .step(wr_ok), .idx(wr_idx)
  );

  zero_run_det #(.BYTE_W(BYTE_W), .RUN(NUM_BYTES)) u_zero_run (
    .clk(clk), .rst(rst), .restart(restart), .wr_ok(wr_ok),
    .wr_byte(wr_data), .fire(zero_fire)
  );

  acc_core #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_core (
    .clk(clk), .rst(rst), .zero_all(zero_all), .add_en(add_en),
    .add_val(res_value), .wr_en(wr_ok), .wr_idx(wr_idx), .wr_byte(wr_data),
    .rd_en(rd_strobe), .rd_idx(rd_idx), .acc_q(acc_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/acc_port_chk.sv
module acc_port_chk #(
  parameter int ACC_W     = 40,
  parameter int NUM_BYTES = 5,
  parameter int IW        = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_strobe,
  input logic             wr_strobe,
  input logic             res_valid,
  input logic [1:0]       res_op,
  input logic [ACC_W-1:0] res_value,
  input logic             clr_cmd,
  input logic             start_cmd,
  input logic [ACC_W-1:0] acc_q,
  input logic [IW-1:0]    rd_idx,
  input logic [IW-1:0]    wr_idx
);
  logic any_restart;
  assign any_restart = res_valid || clr_cmd || start_cmd;

  AST_ACC_ADD: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_op[1] && !clr_cmd |=> acc_q == $past(acc_q) + $past(res_value)); // R2

  AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_op[1] && !clr_cmd |=> $stable(acc_q)); // R3

  AST_RD_LOCK: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !any_restart && rd_idx == '0 |=> rd_idx == '0); // R5

  AST_WR_LOCK: assert property (@(posedge clk) disable iff (rst)
    wr_strobe && !any_restart && wr_idx == IW'(NUM_BYTES - 1) |=> wr_idx == IW'(NUM_BYTES - 1)); // R7

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (rst)
    any_restart |=> rd_idx == IW'(NUM_BYTES - 1) && wr_idx == '0); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> acc_q == '0); // R9

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !wr_strobe && !res_valid && !clr_cmd |=> $stable(acc_q)); // R11

  AST_WR_DROPPED: assert property (@(posedge clk) disable iff (rst)
    wr_strobe && start_cmd && !res_valid && !clr_cmd |=> $stable(acc_q)); // R13
endmodule

bind byte_accum_port acc_port_chk #(.ACC_W(ACC_W), .NUM_BYTES(NUM_BYTES), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .res_valid(res_valid), .res_op(res_op), .res_value(res_value),
  .clr_cmd(clr_cmd), .start_cmd(start_cmd), .acc_q(acc_q),
  .rd_idx(rd_idx), .wr_idx(wr_idx)
);

// File: tb/byte_accum_port_tb_top.sv
`timescale 1ns/1ps
module byte_accum_port_tb_top;
  localparam int NB = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_strobe = 1'b0;
  logic [7:0]  rd_data;
  logic        wr_strobe = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        res_valid = 1'b0;
  logic [39:0] res_value = '0;
  logic [1:0]  res_op = '0;
  logic        clr_cmd = 1'b0;
  logic        start_cmd = 1'b0;

  always #2.5 clk = ~clk;

  byte_accum_port dut_i (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .res_valid(res_valid),
    .res_value(res_value), .res_op(res_op), .clr_cmd(clr_cmd),
    .start_cmd(start_cmd)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference state built from the requirements
  logic [39:0] m_acc = '0;
  int          m_rd = NB - 1;
  int          m_wr = 0;
  int          m_zrun = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_restart();
    m_rd = NB - 1;
    m_wr = 0;
    m_zrun = 0;
  endfunction

  task automatic do_read(string tag);
    exp_q.push_back(m_acc[m_rd*8 +: 8]);
    tag_q.push_back(tag);
    if (m_rd > 0) m_rd--;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < NB; i++) do_read(tag);
  endtask

  task automatic do_write(logic [7:0] b);
    m_acc[m_wr*8 +: 8] = b;
    if (m_wr < NB - 1) m_wr++;
    if (b == 8'h00) begin
      m_zrun++;
      if (m_zrun == NB) begin
        m_acc = '0;
        m_zrun = 0;
      end
    end else begin
      m_zrun = 0;
    end
    wr_strobe = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic do_result(logic [39:0] v, logic [1:0] op, bit with_write);
    if (!op[1]) m_acc = m_acc + v;
    m_restart();
    res_valid = 1'b1;
    res_value = v;
    res_op = op;
    wr_strobe = with_write;
    wr_data = 8'h5A;
    @(negedge clk);
    res_valid = 1'b0;
    wr_strobe = 1'b0;
  endtask

  task automatic do_start();
    m_restart();
    start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
  endtask

  task automatic do_clear();
    m_acc = '0;
    m_restart();
    clr_cmd = 1'b1;
    @(negedge clk);
    clr_cmd = 1'b0;
  endtask

  task automatic load40(logic [39:0] v);
    do_start();
    for (int i = 0; i < NB; i++) do_write(v[i*8 +: 8]);
  endtask

  // Monitor: compare each read result against the scoreboard queue
  initial begin
    forever begin
      bit fired;
      @(posedge clk);
      fired = rd_strobe;
      @(negedge clk);
      if (fired) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected read", {32'h0, rd_data}, 40'h0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rd_data == e, t, {32'h0, rd_data}, {32'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(rd_data == 8'h00, "R1 rd_data after reset", {32'h0, rd_data}, 40'h0);
    read_all("R1 reset sum zero");

    load40(40'h05_04_03_02_01);           // R6 bytes land LSB first
    do_start();
    read_all("R4 R6 MSB-first read order");
    repeat (3) do_read("R5 read pointer locks at byte 0");
    do_start();
    read_all("R11 read keeps contents");

    do_result(40'h00_0000_0100, 2'b00, 1'b0);
    read_all("R2 multiply accumulates");
    do_result(40'h01_0000_0001, 2'b01, 1'b0);
    read_all("R2 divide accumulates");
    load40(40'hFF_FFFF_FFFF);
    do_result(40'h00_0000_0002, 2'b00, 1'b0);
    read_all("R2 sum wraps modulo 2^40");

    do_result(40'hAB_CDEF_1234, 2'b10, 1'b0);
    read_all("R3 shift leaves sum");
    do_result(40'h12_3456_789A, 2'b11, 1'b0);
    read_all("R3 normalize leaves sum");

    do_start();
    do_write(8'h10); do_write(8'h20); do_write(8'h30);
    do_write(8'h40); do_write(8'h50); do_write(8'h60);
    do_start();
    read_all("R7 write pointer locks at byte 4");

    do_start();
    do_write(8'hC1); do_write(8'hC2);
    do_start();
    do_write(8'hD1);
    do_read("R8 start restarts pointers");
    do_read("R8 start restarts pointers");
    do_result(40'h0, 2'b10, 1'b0);
    read_all("R8 result restarts pointers");

    do_clear();
    read_all("R9 clear zeroes sum");

    load40(40'h00_0000_0000);
    do_start();
    do_write(8'h11);
    repeat (5) do_write(8'h00);
    do_start();
    read_all("R10 five zero writes clear all");

    do_start();
    do_write(8'h77); do_write(8'h00); do_write(8'h00); do_write(8'h00);
    do_write(8'h09);
    repeat (4) do_write(8'h00);
    do_start();
    read_all("R10 nonzero write restarts run");

    load40(40'h05_04_03_02_01);
    do_start();
    repeat (4) do_write(8'h00);
    do_start();
    do_write(8'h00);
    do_start();
    read_all("R10 pointer restart restarts run");

    load40(40'hAA_BBCC_DDEE);
    do_start();
    do_write(8'h34); do_write(8'h12);
    do_start();
    read_all("R12 partial load keeps other bytes");

    do_result(40'h00_0000_0001, 2'b00, 1'b1);
    read_all("R13 write with result dropped");
    do_write(8'hE7);
    do_start();
    read_all("R13 write pointer unchanged by dropped write");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule